// File: doc/BRIEF.md
# Hierarchical Device Status Register

This block holds the top-level status byte of a sensor device. It takes error flags from three groups (supply, memory/temperature and communication) and from the pressure signal processing status. It folds each group into a single summary bit. The summary bits are registered once, so a read sees a stable value. The byte also carries three flags with their own rules. The test-mode flag holds until a test operation clears it. The device-reset flag clears on a read of the byte or when the byte is sent in a response status field. The initialization flag clears once sensor data becomes valid.

A host interface issues a one-cycle read strobe with an address. The selected byte appears on `rd_data` one clock later and stays there until the next strobe. Two addresses are decoded: `0x01` is the summary byte and `0x02` is the supply detail byte. Every other address reads as zero. The serial interface, the signal processing and the memory checkers are outside this block and only supply its inputs.

Top module: `dev_status_regs`

## Requirements
- R1: Summary bit 7 is the OR of the five `dsp_err` inputs, sampled one clock earlier.
- R2: Summary bit 5 is the OR of the `comm_err` inputs, sampled one clock earlier. Summary bit 6 always reads 0.
- R3: Summary bit 4 is the OR of the five `mem_err` inputs, sampled one clock earlier.
- R4: Summary bit 3 is the OR of `sup_err[5:1]`, sampled one clock earlier. `sup_err[0]` (continuity) does not affect bit 3. The bit meanings are [5] undervoltage, [4] overvoltage, [3] analog regulator, [2] internal regulator and [1] digital regulator.
- R5: Summary bit 2 (test mode) is 0 after reset. It becomes 1 the clock after `test_set` and stays 1 until the clock after `test_clr`.
- R6: Summary bit 1 (device reset) is 1 after reset and after any `reset_evt` pulse. A summary read returns the flag, and the flag then clears. A `stat_tx` pulse also clears it. If `reset_evt` arrives in the same cycle as either clear, the flag stays set.
- R7: Summary bit 0 (initialization) is 1 after reset and after `reset_evt`. It clears the clock after `data_valid`. If `reset_evt` and `data_valid` arrive in the same cycle, the flag stays set.
- R8: A summary read issued in the first cycle after reset returns these reset values: bit 7 = 1, bits 5 and 4 = 0, bit 3 = the OR of `sup_err[5:1]` during reset, bit 2 = 0, and bits 1 and 0 = 1.
- R9: Address `0x02` returns the sources registered one clock earlier in this layout: {undervoltage, 0, overvoltage, 0, analog regulator, internal regulator, digital regulator, continuity}.
- R10: A read of any address other than `0x01` or `0x02` returns `0x00`. It does not clear any flag.
- R11: `rd_data` updates only on the clock edge that samples `rd_en`, and it holds its value between reads. It is `0x00` after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| dsp_err | input | 5 | Signal processing error sources |
| comm_err | input | 1 | Communication error sources |
| mem_err | input | 5 | Memory and temperature error sources |
| sup_err | input | 6 | Supply error sources, layout as in R4/R9, [0] continuity |
| test_set | input | 1 | Test mode entered |
| test_clr | input | 1 | Test operation that clears test mode |
| reset_evt | input | 1 | Device reset occurred (sets reset and init flags) |
| data_valid | input | 1 | Sensor data became valid |
| stat_tx | input | 1 | Status field carrying the reset flag was transmitted |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Registered read data |

## Verification
The bench checks that the first read after reset returns the forced reset values rather than the live ORs. A design that registered the ORs at reset would return 0 in bit 7. The bench reads the summary twice in a row. A design that cleared the reset flag before returning it, or never cleared it, fails one of those two reads. It also drives `reset_evt` together with the read strobe, with `data_valid` and with `stat_tx`, where a clear-first design would lose the new event. Reads of unused addresses must leave the reset flag untouched. The supply vectors separate the continuity bit from the summary OR and check every bit position of the detail byte.

// File: rtl/dev_status_pkg.sv
package dev_status_pkg;
  localparam int SUMMARY_ADDR = 1;
  localparam int SUPPLY_ADDR  = 2;
  localparam int DSP_W        = 5;
  localparam int MEM_W        = 5;
  localparam int COMM_W       = 1;
  localparam int SUP_W        = 6;
  // summary byte bit positions
  localparam int B_DSP   = 7;
  localparam int B_COMM  = 5;
  localparam int B_MEM   = 4;
  localparam int B_SUP   = 3;
  localparam int B_TEST  = 2;
  localparam int B_RES   = 1;
  localparam int B_INIT  = 0;
endpackage

// File: rtl/ds_or_stage.sv
module ds_or_stage #(
  parameter int W          = 5,
  parameter bit RST_VAL    = 1'b0,
  parameter bit RST_FOLLOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src,
  output logic         flag_q
);
  logic any_set;
  assign any_set = |src;

  generate
    if (RST_FOLLOW) begin : g_follow
      always_ff @(posedge clk) flag_q <= any_set;
    end else begin : g_fixed
      always_ff @(posedge clk) begin
        if (rst) flag_q <= RST_VAL;
        else     flag_q <= any_set;
      end
    end
  endgenerate
endmodule

// File: rtl/ds_sticky_flag.sv
module ds_sticky_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)        flag_q <= RST_VAL;
    else if (set_i) flag_q <= 1'b1;   // a set wins over a clear in the same cycle
    else if (clr_i) flag_q <= 1'b0;
  end
endmodule

// File: rtl/ds_readback.sv
module ds_readback
  import dev_status_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        summary,
  input  logic [7:0]        supply_reg,
  output logic [7:0]        rd_data
);
  localparam logic [ADDR_W-1:0] A_SUM = ADDR_W'(SUMMARY_ADDR);
  localparam logic [ADDR_W-1:0] A_SUP = ADDR_W'(SUPPLY_ADDR);

  logic [7:0] sel;
  always_comb begin
    if (rd_addr == A_SUM)      sel = summary;
    else if (rd_addr == A_SUP) sel = supply_reg;
    else                       sel = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= 8'h00;
    else if (rd_en) rd_data <= sel;
  end
endmodule

// File: rtl/dev_status_regs.sv
module dev_status_regs
  import dev_status_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DSP_W-1:0]  dsp_err,
  input  logic [COMM_W-1:0] comm_err,
  input  logic [MEM_W-1:0]  mem_err,
  input  logic [SUP_W-1:0]  sup_err,
  input  logic              test_set,
  input  logic              test_clr,
  input  logic              reset_evt,
  input  logic              data_valid,
  input  logic              stat_tx,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam logic [ADDR_W-1:0] A_SUM = ADDR_W'(SUMMARY_ADDR);

  logic dsp_q, comm_q, mem_q, sup_q;
  logic test_q, devres_q, init_q;
  logic sum_rd;
  logic [SUP_W-1:0] sup_src_q;
  logic [7:0] summary, supply_reg;

  ds_or_stage #(.W(DSP_W), .RST_VAL(1'b1), .RST_FOLLOW(1'b0)) u_dsp (
    .clk(clk), .rst(rst), .src(dsp_err), .flag_q(dsp_q));
  ds_or_stage #(.W(COMM_W), .RST_VAL(1'b0), .RST_FOLLOW(1'b0)) u_comm (
    .clk(clk), .rst(rst), .src(comm_err), .flag_q(comm_q));
  ds_or_stage #(.W(MEM_W), .RST_VAL(1'b0), .RST_FOLLOW(1'b0)) u_mem (
    .clk(clk), .rst(rst), .src(mem_err), .flag_q(mem_q));
  // continuity (bit 0) is reported in the detail byte only
  ds_or_stage #(.W(SUP_W-1), .RST_VAL(1'b0), .RST_FOLLOW(1'b1)) u_sup (
    .clk(clk), .rst(rst), .src(sup_err[SUP_W-1:1]), .flag_q(sup_q));

  always_ff @(posedge clk) sup_src_q <= sup_err;

  assign sum_rd = rd_en && (rd_addr == A_SUM);

  ds_sticky_flag #(.RST_VAL(1'b0)) u_test (
    .clk(clk), .rst(rst), .set_i(test_set), .clr_i(test_clr), .flag_q(test_q));
  ds_sticky_flag #(.RST_VAL(1'b1)) u_devres (
    .clk(clk), .rst(rst), .set_i(reset_evt), .clr_i(sum_rd | stat_tx), .flag_q(devres_q));
  ds_sticky_flag #(.RST_VAL(1'b1)) u_init (
    .clk(clk), .rst(rst), .set_i(reset_evt), .clr_i(data_valid), .flag_q(init_q));

  always_comb begin
    summary          = 8'h00;
    summary[B_DSP]   = dsp_q;
    summary[B_COMM]  = comm_q;
    summary[B_MEM]   = mem_q;
    summary[B_SUP]   = sup_q;
    summary[B_TEST]  = test_q;
    summary[B_RES]   = devres_q;
    summary[B_INIT]  = init_q;
  end

  assign supply_reg = {sup_src_q[5], 1'b0, sup_src_q[4], 1'b0,
                       sup_src_q[3], sup_src_q[2], sup_src_q[1], sup_src_q[0]};

  ds_readback #(.ADDR_W(ADDR_W)) u_rb (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .summary(summary), .supply_reg(supply_reg), .rd_data(rd_data));
endmodule

// File: rtl/ds_status_chk.sv
module ds_status_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              reset_evt,
  input logic              stat_tx,
  input logic              data_valid,
  input logic              devres_q,
  input logic              init_q,
  input logic [7:0]        rd_data
);
  localparam logic [ADDR_W-1:0] A_SUM = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SUP = ADDR_W'(2);

  // R6
  devres_set_chk: assert property (@(posedge clk) disable iff (rst)
    reset_evt |=> devres_q);
  // R6
  devres_rdclr_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == A_SUM && !reset_evt) |=> !devres_q);
  // R6
  devres_txclr_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_tx && !reset_evt) |=> !devres_q);
  // R7
  init_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (data_valid && !reset_evt) |=> !init_q);
  // R7
  init_set_chk: assert property (@(posedge clk) disable iff (rst)
    reset_evt |=> init_q);
  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == A_SUM) |=> !rd_data[6]);
  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr != A_SUM && rd_addr != A_SUP) |=> rd_data == 8'h00);
  // R10
  unmapped_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr != A_SUM && !stat_tx && devres_q) |=> devres_q);
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind dev_status_regs ds_status_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
  .reset_evt(reset_evt), .stat_tx(stat_tx), .data_valid(data_valid),
  .devres_q(devres_q), .init_q(init_q), .rd_data(rd_data));

// File: tb/tb_dev_status_regs.sv
module tb_dev_status_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] dsp_err = '0;
  logic [0:0] comm_err = '0;
  logic [4:0] mem_err = '0;
  logic [5:0] sup_err = '0;
  logic test_set = 0, test_clr = 0, reset_evt = 0, data_valid = 0, stat_tx = 0, rd_en = 0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  dev_status_regs dut (
    .clk(clk), .rst(rst), .dsp_err(dsp_err), .comm_err(comm_err), .mem_err(mem_err),
    .sup_err(sup_err), .test_set(test_set), .test_clr(test_clr), .reset_evt(reset_evt),
    .data_valid(data_valid), .stat_tx(stat_tx), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data));

  // {dsp, comm, mem, sup, expected summary, expected supply byte}
  localparam int NV = 10;
  localparam logic [32:0] VEC [NV] = '{
    {5'b00000, 1'b0, 5'b00000, 6'b000000, 8'h00, 8'h00},
    {5'b00001, 1'b0, 5'b00000, 6'b000000, 8'h80, 8'h00},
    {5'b10000, 1'b1, 5'b00000, 6'b000000, 8'hA0, 8'h00},
    {5'b00000, 1'b0, 5'b00100, 6'b000000, 8'h10, 8'h00},
    {5'b00000, 1'b0, 5'b00000, 6'b000001, 8'h00, 8'h01},
    {5'b00000, 1'b0, 5'b00000, 6'b100000, 8'h08, 8'h80},
    {5'b00000, 1'b0, 5'b00000, 6'b010000, 8'h08, 8'h20},
    {5'b00000, 1'b0, 5'b00000, 6'b001110, 8'h08, 8'h0E},
    {5'b11111, 1'b1, 5'b11111, 6'b111111, 8'hB8, 8'hAF},
    {5'b01000, 1'b0, 5'b00001, 6'b000010, 8'h98, 8'h02}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0;
    v = rd_data;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    dsp_err = 5'b00000; comm_err = 1'b1; mem_err = 5'b00010; sup_err = 6'b100000;
    repeat (3) @(negedge clk);
    check("R11 reset rd_data", rd_data, 8'h00);
    // R8: read in the first cycle after reset
    rst = 0; rd_en = 1; rd_addr = 8'h01;
    @(negedge clk); rd_en = 0;
    check("R8 reset value", rd_data, 8'h8B);
    rd(8'h01, v); check("R6 cleared by read / R1 R2 R3 R4 live", v, 8'h39);
    pulse(data_valid);
    dsp_err = '0; comm_err = '0; mem_err = '0; sup_err = '0;
    @(negedge clk);
    rd(8'h01, v); check("R7 init cleared", v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      {dsp_err, comm_err, mem_err, sup_err} = VEC[i][32:16];
      @(negedge clk);
      rd(8'h01, v); check("R1 R2 R3 R4 summary vector", v, VEC[i][15:8]);
      rd(8'h02, v); check("R9 supply byte vector", v, VEC[i][7:0]);
    end
    dsp_err = '0; comm_err = '0; mem_err = '0; sup_err = '0;
    @(negedge clk);

    // R6 / R7 reset event
    pulse(reset_evt);
    rd(8'h01, v); check("R6 set by reset_evt", v, 8'h03);
    rd(8'h01, v); check("R6 cleared after read", v, 8'h01);
    pulse(reset_evt);
    pulse(stat_tx);
    rd(8'h01, v); check("R6 cleared by stat_tx", v, 8'h01);
    // R6 priority: reset_evt with a summary read
    pulse(data_valid);
    @(negedge clk); reset_evt = 1; rd_en = 1; rd_addr = 8'h01;
    @(negedge clk); reset_evt = 0; rd_en = 0;
    check("R6 read during set returns old", rd_data, 8'h00);
    rd(8'h01, v); check("R6 set wins over read clear", v, 8'h03);
    // R7 priority: reset_evt with data_valid
    @(negedge clk); reset_evt = 1; data_valid = 1;
    @(negedge clk); reset_evt = 0; data_valid = 0;
    rd(8'h01, v); check("R7 set wins over data_valid", v, 8'h03);
    // R6 priority: reset_evt with stat_tx
    @(negedge clk); reset_evt = 1; stat_tx = 1;
    @(negedge clk); reset_evt = 0; stat_tx = 0;
    pulse(data_valid);
    rd(8'h01, v); check("R6 set wins over stat_tx", v, 8'h02);
    rd(8'h01, v); check("R6 read clear", v, 8'h00);

    // R5 test mode
    pulse(test_set);
    rd(8'h01, v); check("R5 test set", v, 8'h04);
    repeat (3) @(negedge clk);
    rd(8'h01, v); check("R5 test sticky", v, 8'h04);
    pulse(test_clr);
    rd(8'h01, v); check("R5 test cleared", v, 8'h00);

    // R10 other addresses, no side effect
    pulse(reset_evt);
    pulse(data_valid);
    rd(8'h07, v); check("R10 unmapped reads zero", v, 8'h00);
    rd(8'hFF, v); check("R10 unmapped reads zero", v, 8'h00);
    rd(8'h02, v); check("R10 supply read no side effect", v, 8'h00);
    rd(8'h01, v); check("R10 reset flag kept", v, 8'h02);

    // R11 hold between reads
    dsp_err = 5'b11111; sup_err = 6'b111111;
    repeat (4) @(negedge clk);
    check("R11 hold without strobe", rd_data, 8'h02);
    rd(8'h01, v); check("R11 update on strobe", v, 8'h88);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule